// File: doc/BRIEF.md
# Strap-Selected Bus Memory Bank

A single-ported word memory that hangs on a shared parallel bus made of an address bus, a bidirectional tri-state data bus, a write strobe and a read level. The address space is cut into four equal quarters. Which quarter this module answers to is chosen by a 2-bit strap input. The top two address bits are compared bit by bit against that input. A closed strap contributes a 0 and an open strap contributes a 1. When the compare matches, the remaining low address bits pick one word of the storage array.

A write strobe that is high at a rising clock edge while the module is selected copies the data bus word into the indexed location. While the read level is high and the module is selected, the indexed word is driven onto the data bus with no clock delay. At every other time the module leaves the bus at high impedance, so other modules can share it.

With `ADDR_W` set to 16, the module is a 16K-word by 16-bit bank in a 64K-word space. The default of 12 keeps the elaborated array small, at 1K words per bank.

Top module: `strap_bank_mem`

## Requirements
- R1: The array holds 2^(ADDR_W-2) words of DATA_W bits, and address bits ADDR_W-3:0 index it. Index 0 and index 2^(ADDR_W-2)-1 are both usable.
- R2: The module is selected exactly when address bits ADDR_W-1:ADDR_W-2 equal `strap_i`, compared bit by bit for equality.
- R3: A strap bit value of 0 means closed and 1 means open. Strap value n places the bank at word addresses n*2^(ADDR_W-2) up to (n+1)*2^(ADDR_W-2)-1.
- R4: When `wr_en_i` is high at a rising edge of `clk` while the module is selected, the word on `data_io` is stored at the indexed location.
- R5: A write to an address that is not selected leaves every stored word unchanged.
- R6: While `rd_en_i` is high and the module is selected, the stored word at the indexed location drives `data_io` combinationally, with no clock cycle of delay.
- R7: While `rd_en_i` is low, or while the module is not selected, `data_io` is not driven and stays high impedance.
- R8: `strap_i` is sampled continuously. A changed strap value moves the bank to another quarter for the very next access, and the stored contents are kept.
- R9: In a cycle without a selected write, no stored word changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are taken on its rising edge |
| rst_n | input | 1 | Active-low reset; it gates only the built-in checks, because the storage has no reset |
| addr_i | input | ADDR_W | Bus address; the top two bits select the bank and the rest index the array |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read level |
| strap_i | input | 2 | Bank number from the straps (closed = 0, open = 1) |
| data_io | inout | DATA_W | Shared tri-state data bus |

## Verification
On every clock edge, the assertions check three things: a selected write lands in the indexed word, an unselected write changes nothing at that index, and no word moves in a cycle without a write. While a selected read is active, they also check that the bus carries the stored word. Only the bench scenarios can show the rest. These are the high-impedance release of the bus when the module is idle or not selected, the bank moving when the straps are re-set, data surviving such a move, and the first and last array index in two different banks.

// File: rtl/strap_bank_mem.sv
module strap_bank_mem #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        strap_i,
  inout  wire  [DATA_W-1:0] data_io
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic              drive;

  assign idx   = addr_i[IDX_W-1:0];
  assign hit   = ~|(addr_i[ADDR_W-1 -: 2] ^ strap_i);
  assign drive = rd_en_i & hit;

  assign data_io = drive ? mem[idx] : {DATA_W{1'bz}};

  always_ff @(posedge clk) begin
    if (wr_en_i && hit) mem[idx] <= data_io;
  end

  // R4
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && hit) |=> mem[$past(idx)] == $past(data_io));

  // R5
  a_r5_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !hit) |=> mem[$past(idx)] == $past(mem[idx]));

  // R9
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> mem[$past(idx)] == $past(mem[idx]));

  // R6
  a_r6_read_value: assert property (@(negedge clk) disable iff (!rst_n)
    (rd_en_i && hit && !wr_en_i) |-> data_io == mem[idx]);

endmodule

// File: tb/test_strap_bank_mem.sv
module test_strap_bank_mem;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int DEPTH  = 1 << IDX_W;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr = 0, rd = 0;
  logic [1:0]        strap = 2'd2;
  logic [DATA_W-1:0] tb_d = '0;
  logic              tb_oe = 0;
  wire  [DATA_W-1:0] bus;
  int errors = 0, checks = 0;
  bit done = 0;

  assign bus = tb_oe ? tb_d : {DATA_W{1'bz}};
  always #(CLK_P/2) clk = ~clk;

  strap_bank_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_strap_bank_mem (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .strap_i(strap), .data_io(bus));

  function automatic logic [ADDR_W-1:0] mk(input logic [1:0] b, input int i);
    return {b, IDX_W'(i)};
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a; tb_d = d; tb_oe = 1; wr = 1;
    @(negedge clk);
    wr = 0; tb_oe = 0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a; rd = 1;
    #1 d = bus;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic t_reset_idle;
    logic [DATA_W-1:0] v;
    @(negedge clk);
    v = bus;
    check("R7 idle after reset", v, {DATA_W{1'bz}});
  endtask

  task automatic t_write_read;
    logic [DATA_W-1:0] v;
    do_write(mk(2'd2, 5), 16'hA5C3);
    do_write(mk(2'd2, 6), 16'h0000);
    do_write(mk(2'd2, 7), 16'hFFFF);
    do_read(mk(2'd2, 5), v); check("R4 R6 pattern A5C3", v, 16'hA5C3);
    do_read(mk(2'd2, 6), v); check("R4 R6 pattern 0000", v, 16'h0000);
    do_read(mk(2'd2, 7), v); check("R4 R6 pattern FFFF", v, 16'hFFFF);
  endtask

  task automatic t_edges;
    logic [DATA_W-1:0] v;
    do_write(mk(2'd2, 0), 16'h1234);
    do_write(mk(2'd2, DEPTH-1), 16'h8765);
    do_read(mk(2'd2, 0), v);       check("R1 first index", v, 16'h1234);
    do_read(mk(2'd2, DEPTH-1), v); check("R1 last index", v, 16'h8765);
  endtask

  task automatic t_miss_write;
    logic [DATA_W-1:0] v;
    do_write(mk(2'd0, 5), 16'hDEAD);
    do_write(mk(2'd3, 5), 16'hBEEF);
    do_write(mk(2'd1, 5), 16'hCAFE);
    do_read(mk(2'd2, 5), v); check("R5 R2 unselected write ignored", v, 16'hA5C3);
  endtask

  task automatic t_hiz;
    logic [DATA_W-1:0] v;
    @(negedge clk);
    addr = mk(2'd2, 5); rd = 0;
    #1 v = bus; check("R7 selected but read low", v, {DATA_W{1'bz}});
    addr = mk(2'd1, 5); rd = 1;
    #1 v = bus; check("R7 read high but unselected", v, {DATA_W{1'bz}});
    @(negedge clk); rd = 0;
  endtask

  task automatic t_strap_move;
    logic [DATA_W-1:0] v;
    @(negedge clk); strap = 2'd1;
    do_read(mk(2'd2, 5), v); check("R8 old bank released", v, {DATA_W{1'bz}});
    do_read(mk(2'd1, 5), v); check("R8 R3 new quarter answers", v, 16'hA5C3);
    do_write(mk(2'd1, 9), 16'h5A5A);
    @(negedge clk); strap = 2'd3;
    do_read(mk(2'd3, 9), v); check("R3 open straps top quarter", v, 16'h5A5A);
    do_write(mk(2'd1, 9), 16'h0F0F);
    do_read(mk(2'd3, 9), v); check("R5 write to released quarter", v, 16'h5A5A);
    @(negedge clk); strap = 2'd0;
    do_read(mk(2'd0, DEPTH-1), v); check("R3 closed straps bottom quarter", v, 16'h8765);
  endtask

  task automatic t_hold;
    logic [DATA_W-1:0] v;
    @(negedge clk); addr = mk(2'd0, 7); tb_oe = 1; tb_d = 16'h7777;
    repeat (3) @(negedge clk);
    tb_oe = 0;
    do_read(mk(2'd0, 7), v); check("R9 no write keeps word", v, 16'hFFFF);
  endtask

  initial begin
    fork
      begin : wd
        #(CLK_P*5000);
        if (!done) begin
          errors++; checks++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("Result: errors=%0d of %0d checks", errors, checks);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_idle();
    t_write_read();
    t_edges();
    t_miss_write();
    t_hiz();
    t_strap_move();
    t_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule